// File: doc/BRIEF.md
# Cascaded Display Timing Counter Bank

This block holds eight programmable counters that, chained together, produce the timing strobes and waveforms of a raster display. Examples are horizontal and vertical sync, the line-active window, the pixel-active window, or any other periodic marker. Each counter advances on a trigger event picked by a source select. The trigger is either the pixel clock enable or the wrap strobe of a lower-numbered counter in the same clock cycle. This lets a line counter step on the wrap of a pixel counter, and a frame counter step on the wrap of the line counter.

Each counter has the following programmable settings:
- a period;
- a start delay, counted on its own selectable source;
- a repeat limit, after which it stops;
- a clear source, which re-arms it.

A counter can also shape a level waveform. The waveform rises and falls at programmed count positions, which are written in half-count units. A final inversion bit can be applied to the waveform.

Software loads the configuration through a simple write port while the bank is idle. Raising the enable then starts every counter from zero in the same cycle.

Top module: `sync_wave_bank`

## Requirements
- R1: A configuration write (`cfg_we` high) takes effect only in a cycle where `en` is low; a write presented while `en` is high changes nothing. Address bits [4:2] pick the counter and bits [1:0] pick the word.
  - Word 0 holds the period `run_max` in [11:0], the trigger select in [15:12], the start delay in [27:16] and the delay source select in [31:28].
  - Word 1 holds the repeat limit in [11:0], the clear select in [15:12], the waveform enable in [16] and the inversion bit in [17].
  - Word 2 holds the rise position in [9:0] and the fall position in [25:16].
  - Word 3 is ignored. After reset every field is zero.
- R2: While `en` is low, every counter is held at count zero with its delay and repeat limit reloaded, all strobes are 0, and each waveform output equals its inversion bit. The first enabled cycle starts every counter together from that state.
- R3: A running counter counts 0 to `run_max` on its trigger events, then wraps to 0. The trigger event that wraps it raises its strobe, so the strobe period is `run_max`+1 events.
- R4: The source select encoding is: 0 means no event, 1 means `pix_ce`, and N≥2 means the strobe of counter N−2 (counter index) in the same cycle. A select naming a counter that is not lower-numbered than the selecting counter acts as 0.
- R5: A nonzero start delay D holds the counter, with no strobe, until D events of its delay source have passed; only then does it begin counting trigger events.
- R6: A repeat limit of 0 makes the counter wrap forever. A limit of N>0 stops it after its Nth strobe, with no further strobes until a clear.
- R7: A clear event reloads the counter (count 0, delay, repeat limit, waveform low). A clear has priority over a same-cycle trigger, but a strobe due in that cycle is still emitted.
- R8: With the waveform enabled, after each trigger event the waveform goes low if the new count equals the fall position divided by two (rounded down), else goes high if it equals the rise position divided by two. A rise and fall that resolve to the same count give no pulse. The final strobe of a repeat-limited counter drives the waveform low.
- R9: With the waveform disabled the waveform is 0. The inversion bit inverts the waveform output in either case.
- R10: `stb_o` and `wave_o` are registered: they show the result of the cycle whose inputs were sampled at the same clock edge that updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds counters and opens configuration |
| pix_ce | input | 1 | Pixel clock enable, trigger source 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address {counter, word} |
| cfg_wdata | input | 32 | Configuration write data |
| stb_o | output | 8 | Registered wrap strobe per counter |
| wave_o | output | 8 | Registered waveform per counter |

## Verification
The bench goes after several corner cases.
- A counter that selects a higher-numbered source must stay silent; a design that decoded the select without the ordering check would strobe when that later counter wraps.
- A start delay must cost exactly D source events; an off-by-one would shift every pixel-active window by one pixel.
- A repeat-limited counter must stop after exactly N strobes and ignore a repeat rewrite made while running; a broken write lock would turn it into a free-running counter.
- A rise and fall at the same position, clear-over-trigger priority and the inversion of an idle waveform are each compared against a cycle-exact reference under random pixel enables.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int MAX_CTR = 8;
  localparam int CNT_W   = 12;
  localparam int POS_W   = 10;
  localparam int SEL_W   = $clog2(MAX_CTR + 2);
  localparam int PIDX_W  = $clog2(MAX_CTR);

  // word 0 field offsets
  localparam int F_RMAX = 0;
  localparam int F_RSEL = CNT_W;
  localparam int F_OFS  = 16;
  localparam int F_OSEL = 16 + CNT_W;
  // word 1 field offsets
  localparam int F_REP  = 0;
  localparam int F_CSEL = CNT_W;
  localparam int F_POL  = 16;
  localparam int F_INV  = 17;
  // word 2 field offsets
  localparam int F_UP   = 0;
  localparam int F_DN   = 16;

  typedef struct packed {
    logic [CNT_W-1:0] run_max;
    logic [SEL_W-1:0] run_sel;
    logic [CNT_W-1:0] ofs_cnt;
    logic [SEL_W-1:0] ofs_sel;
    logic [CNT_W-1:0] rep_cnt;
    logic [SEL_W-1:0] clr_sel;
    logic             pol_en;
    logic             inv;
    logic [POS_W-1:0] up_pos;
    logic [POS_W-1:0] dn_pos;
  } ctr_cfg_t;

  typedef enum logic [1:0] {PH_DLY = 2'd0, PH_RUN = 2'd1, PH_DONE = 2'd2} phase_t;
endpackage

// File: rtl/sb_cfg_regs.sv
module sb_cfg_regs
  import sb_pkg::*;
#(
  parameter int N_CTR  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctr_cfg_t          cfg_o [N_CTR]
);
  localparam int IDX_W = ADDR_W - 2;

  ctr_cfg_t regs_q [N_CTR];

  for (genvar g = 0; g < N_CTR; g++) begin : g_reg
    logic hit;
    assign hit = we && !lock && (addr[ADDR_W-1:2] == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        case (addr[1:0])
          2'd0: begin
            regs_q[g].run_max <= wdata[F_RMAX +: CNT_W];
            regs_q[g].run_sel <= wdata[F_RSEL +: SEL_W];
            regs_q[g].ofs_cnt <= wdata[F_OFS  +: CNT_W];
            regs_q[g].ofs_sel <= wdata[F_OSEL +: SEL_W];
          end
          2'd1: begin
            regs_q[g].rep_cnt <= wdata[F_REP  +: CNT_W];
            regs_q[g].clr_sel <= wdata[F_CSEL +: SEL_W];
            regs_q[g].pol_en  <= wdata[F_POL];
            regs_q[g].inv     <= wdata[F_INV];
          end
          2'd2: begin
            regs_q[g].up_pos  <= wdata[F_UP +: POS_W];
            regs_q[g].dn_pos  <= wdata[F_DN +: POS_W];
          end
          default: ;
        endcase
      end
    end

    assign cfg_o[g] = regs_q[g];

    // R1: configuration is frozen while the bank runs
    a_r1_frozen_when_running: assert property (@(posedge clk) disable iff (rst)
      lock |=> $stable(regs_q[g]));
  end
endmodule

// File: rtl/sb_counter.sv
module sb_counter
  import sb_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  ctr_cfg_t           cfg,
  input  logic               pix_ce,
  input  logic [MAX_CTR-1:0] prior,
  output logic               stb,
  output logic               stb_o,
  output logic               wave_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] rep_q, rep_d;
  phase_t           phase_q, phase_d;
  logic             wave_q, wave_d;
  logic             t_run, t_dly, t_clr;

  function automatic logic pick(input logic [SEL_W-1:0] sel,
                                input logic pix,
                                input logic [MAX_CTR-1:0] lower);
    int k;
    k = int'(sel) - 2;
    if (sel == '0) return 1'b0;
    if (sel == SEL_W'(1)) return pix;
    if (k < IDX) return lower[k[PIDX_W-1:0]];
    return 1'b0;
  endfunction

  assign t_run = pick(cfg.run_sel, pix_ce, prior);
  assign t_dly = pick(cfg.ofs_sel, pix_ce, prior);
  assign t_clr = pick(cfg.clr_sel, pix_ce, prior);

  assign stb = run && (phase_q == PH_RUN) && t_run && (cnt_q == cfg.run_max);

  always_comb begin
    cnt_d   = cnt_q;
    dly_d   = dly_q;
    rep_d   = rep_q;
    phase_d = phase_q;
    wave_d  = wave_q;
    if (!run || t_clr) begin
      cnt_d   = '0;
      dly_d   = cfg.ofs_cnt;
      rep_d   = cfg.rep_cnt;
      phase_d = (cfg.ofs_cnt != '0) ? PH_DLY : PH_RUN;
      wave_d  = 1'b0;
    end else begin
      case (phase_q)
        PH_DLY: begin
          if (t_dly) begin
            if (dly_q <= CNT_W'(1)) phase_d = PH_RUN;
            else                    dly_d   = dly_q - CNT_W'(1);
          end
        end
        PH_RUN: begin
          if (t_run) begin
            if (cnt_q == cfg.run_max) begin
              cnt_d = '0;
              if (cfg.rep_cnt != '0) begin
                if (rep_q <= CNT_W'(1)) phase_d = PH_DONE;
                else                    rep_d   = rep_q - CNT_W'(1);
              end
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
            if (phase_d == PH_DONE)                          wave_d = 1'b0;
            else if (cnt_d == CNT_W'(cfg.dn_pos >> 1))       wave_d = 1'b0;
            else if (cnt_d == CNT_W'(cfg.up_pos >> 1))       wave_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (!cfg.pol_en) wave_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      dly_q   <= '0;
      rep_q   <= '0;
      phase_q <= PH_RUN;
      wave_q  <= 1'b0;
      stb_o   <= 1'b0;
      wave_o  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      dly_q   <= dly_d;
      rep_q   <= rep_d;
      phase_q <= phase_d;
      wave_q  <= wave_d;
      stb_o   <= stb;
      wave_o  <= wave_d ^ cfg.inv;
    end
  end

  // R3: the count never passes the programmed period while running
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (run && phase_q == PH_RUN) |-> (cnt_q <= cfg.run_max));

  // R5: a counter still in its start delay emits no strobe
  a_r5_delay_silent: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DLY) |=> !stb_o);

  // R6: a stopped counter stays stopped until a clear and stays silent
  a_r6_done_sticks: assert property (@(posedge clk) disable iff (rst)
    (run && phase_q == PH_DONE && !t_clr) |=> (phase_q == PH_DONE));
  a_r6_done_silent: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE) |=> !stb_o);

  // R9: with the waveform disabled only the inversion bit reaches the output
  a_r9_plain_level: assert property (@(posedge clk) disable iff (rst)
    !cfg.pol_en |=> (wave_o == $past(cfg.inv)));
endmodule

// File: rtl/sync_wave_bank.sv
module sync_wave_bank
  import sb_pkg::*;
#(
  parameter int N_CTR  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(N_CTR) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pix_ce,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [N_CTR-1:0]  stb_o,
  output logic [N_CTR-1:0]  wave_o
);
  ctr_cfg_t           cfg_w [N_CTR];
  logic [MAX_CTR-1:0] stb_all;

  sb_cfg_regs #(
    .N_CTR (N_CTR),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk  (clk),
    .rst  (rst),
    .lock (en),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .cfg_o(cfg_w)
  );

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    localparam logic [MAX_CTR-1:0] LOW_MASK = (MAX_CTR'(1) << g) - MAX_CTR'(1);
    logic [MAX_CTR-1:0] lower;
    assign lower = stb_all & LOW_MASK;

    sb_counter #(.IDX(g)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .run   (en),
      .cfg   (cfg_w[g]),
      .pix_ce(pix_ce),
      .prior (lower),
      .stb   (stb_all[g]),
      .stb_o (stb_o[g]),
      .wave_o(wave_o[g])
    );
  end

  for (genvar g = N_CTR; g < MAX_CTR; g++) begin : g_pad
    assign stb_all[g] = 1'b0;
  end

  // R2: an idle bank emits no strobes
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (stb_o == '0));
endmodule

// File: tb/sim_sync_wave_bank.sv
module sim_sync_wave_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       pix_ce = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0] stb_o, wave_o;

  always #2 clk = ~clk;

  sync_wave_bank u0 (
    .clk(clk), .rst(rst), .en(en), .pix_ce(pix_ce),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stb_o(stb_o), .wave_o(wave_o)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit armed = 0;
  bit done = 0;
  string cur_req = "R2";

  // reference model state
  int mc_max[8], mc_rs[8], mc_ofs[8], mc_os[8], mc_rep[8], mc_cs[8];
  int mc_up[8], mc_dn[8];
  bit mc_pol[8], mc_inv[8];
  int m_cnt[8], m_dly[8], m_rep[8], m_ph[8];
  bit m_wave[8];
  bit [7:0] exp_stb, exp_wave;

  function automatic bit src(int sel, int i, bit pix, bit [7:0] s);
    if (sel == 0) return 1'b0;
    if (sel == 1) return pix;
    if (sel - 2 < i) return s[sel-2];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit [7:0] s;
    bit [7:0] nw;
    bit tr, td, tc;
    int idx, wd;
    armed <= 1'b1;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        mc_max[i] = 0; mc_rs[i] = 0; mc_ofs[i] = 0; mc_os[i] = 0;
        mc_rep[i] = 0; mc_cs[i] = 0; mc_up[i] = 0; mc_dn[i] = 0;
        mc_pol[i] = 0; mc_inv[i] = 0;
        m_cnt[i] = 0; m_dly[i] = 0; m_rep[i] = 0; m_ph[i] = 1; m_wave[i] = 0;
      end
      exp_stb = '0;
      exp_wave = '0;
    end else begin
      s = '0;
      for (int i = 0; i < 8; i++) begin
        tr = src(mc_rs[i], i, pix_ce, s);
        td = src(mc_os[i], i, pix_ce, s);
        tc = src(mc_cs[i], i, pix_ce, s);
        s[i] = en && m_ph[i] == 1 && tr && m_cnt[i] == mc_max[i];
        if (!en || tc) begin
          m_cnt[i] = 0; m_dly[i] = mc_ofs[i]; m_rep[i] = mc_rep[i];
          m_ph[i] = (mc_ofs[i] != 0) ? 0 : 1; m_wave[i] = 0;
        end else if (m_ph[i] == 0) begin
          if (td) begin
            if (m_dly[i] <= 1) m_ph[i] = 1; else m_dly[i]--;
          end
        end else if (m_ph[i] == 1 && tr) begin
          if (m_cnt[i] == mc_max[i]) begin
            m_cnt[i] = 0;
            if (mc_rep[i] != 0) begin
              if (m_rep[i] <= 1) m_ph[i] = 2; else m_rep[i]--;
            end
          end else m_cnt[i]++;
          if (m_ph[i] == 2) m_wave[i] = 0;
          else if (m_cnt[i] == mc_dn[i] / 2) m_wave[i] = 0;
          else if (m_cnt[i] == mc_up[i] / 2) m_wave[i] = 1;
        end
        if (!mc_pol[i]) m_wave[i] = 0;
        nw[i] = m_wave[i] ^ mc_inv[i];
      end
      exp_stb = s;
      exp_wave = nw;
      if (cfg_we && !en) begin
        idx = int'(cfg_addr[4:2]);
        wd = int'(cfg_addr[1:0]);
        if (wd == 0) begin
          mc_max[idx] = int'(cfg_wdata[11:0]); mc_rs[idx] = int'(cfg_wdata[15:12]);
          mc_ofs[idx] = int'(cfg_wdata[27:16]); mc_os[idx] = int'(cfg_wdata[31:28]);
        end else if (wd == 1) begin
          mc_rep[idx] = int'(cfg_wdata[11:0]); mc_cs[idx] = int'(cfg_wdata[15:12]);
          mc_pol[idx] = cfg_wdata[16]; mc_inv[idx] = cfg_wdata[17];
        end else if (wd == 2) begin
          mc_up[idx] = int'(cfg_wdata[9:0]); mc_dn[idx] = int'(cfg_wdata[25:16]);
        end
      end
    end
  end

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (armed && !rst && !done) begin
      nchk++;
      if (stb_o !== exp_stb || wave_o !== exp_wave) begin
        nerr++;
        $display("FAIL %s: stb=%b wave=%b expected stb=%b wave=%b",
                 cur_req, stb_o, wave_o, exp_stb, exp_wave);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog R2: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input int w, input logic [31:0] d);
    cfg_we = 1'b1;
    cfg_addr = {3'(i), 2'(w)};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfgc(input int i, input int rmax, input int rs, input int ofs, input int os,
                      input int rep, input int cs, input bit pol, input bit inv,
                      input int up, input int dn);
    wr(i, 0, {4'(os), 12'(ofs), 4'(rs), 12'(rmax)});
    wr(i, 1, {14'b0, inv, pol, 4'(cs), 12'(rep)});
    wr(i, 2, {6'b0, 10'(dn), 6'b0, 10'(up)});
  endtask

  initial begin
    int c0, c1, c2, c3, c4, c4first, c6hi, c5low, c5run, c6tot;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(stb_o == '0 && wave_o == '0, "R2", int'({stb_o, wave_o}), 0);
    rst = 1'b0;
    @(negedge clk);

    // scenario 1: steady pixel enable
    cur_req = "R3/R4/R7/R8";
    cfgc(0, 3, 1, 0, 0, 0, 0, 1, 0, 0, 2);
    cfgc(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    cfgc(2, 100, 1, 0, 0, 0, 2, 0, 0, 0, 0);
    cfgc(3, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
    cfgc(4, 0, 1, 5, 1, 3, 0, 0, 0, 0, 0);
    cfgc(5, 9, 1, 0, 0, 0, 0, 1, 1, 0, 6);
    cfgc(6, 9, 1, 0, 0, 0, 0, 1, 0, 3, 3);
    cfgc(7, 2, 3, 0, 0, 0, 0, 1, 0, 1, 4);
    pix_ce = 1'b1;
    en = 1'b1;
    c0 = 0; c1 = 0; c2 = 0; c3 = 0; c4 = 0; c4first = -1; c6hi = 0; c5low = 0; c5run = 0;
    for (int k = 0; k <= 400; k++) begin
      @(negedge clk);
      c0 += int'(stb_o[0]); c1 += int'(stb_o[1]); c2 += int'(stb_o[2]); c3 += int'(stb_o[3]);
      if (stb_o[4]) begin
        if (c4first < 0) c4first = k;
        c4++;
      end
      c6hi += int'(wave_o[6]);
      if (!wave_o[5]) begin
        c5run++;
        if (c5run > c5low) c5low = c5run;
      end else c5run = 0;
    end
    chk(c0 == 100, "R3 period strobes", c0, 100);
    chk(c1 == 50, "R4 chained trigger", c1, 50);
    chk(c3 == 0, "R4 later source ignored", c3, 0);
    chk(c2 == 0, "R7 clear before wrap", c2, 0);
    chk(c4first == 5, "R5 start delay", c4first, 5);
    chk(c4 == 3, "R6 repeat limit", c4, 3);
    chk(c6hi == 0, "R8 coincident edges", c6hi, 0);
    chk(c5low == 3, "R9 inverted pulse width", c5low, 3);

    // R2: idle outputs
    cur_req = "R2";
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(stb_o == '0, "R2 idle strobes", int'(stb_o), 0);
      chk(wave_o == 8'b0010_0000, "R2 idle level", int'(wave_o), 32);
    end

    // scenario 2: display-like chain under random pixel enables
    cur_req = "R5/R6/R7/R10";
    cfgc(0, 19, 1, 0, 0, 0, 0, 1, 0, 0, 6);
    cfgc(1, 9, 2, 0, 0, 0, 0, 1, 0, 0, 4);
    cfgc(2, 0, 2, 2, 2, 5, 3, 0, 0, 0, 0);
    cfgc(3, 0, 1, 4, 1, 10, 4, 0, 0, 0, 0);
    cfgc(4, 3, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    cfgc(5, 1, 6, 3, 5, 0, 0, 1, 0, 0, 1);
    cfgc(6, 0, 1, 0, 0, 4, 0, 0, 0, 0, 0);
    cfgc(7, 5, 7, 0, 0, 0, 8, 1, 0, 3, 9);
    en = 1'b1;
    c6tot = 0;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      c6tot += int'(stb_o[6]);
      pix_ce = ($urandom % 3) != 0;
    end
    // R1: writes while running must not land
    cur_req = "R1";
    wr(6, 1, 32'h0);
    c6tot += int'(stb_o[6]);
    wr(0, 0, {4'd0, 12'd0, 4'd1, 12'd2});
    c6tot += int'(stb_o[6]);
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      c6tot += int'(stb_o[6]);
      pix_ce = ($urandom % 2) != 0;
    end
    chk(c6tot == 4, "R1 locked repeat limit", c6tot, 4);
    en = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule